// File: doc/BRIEF.md
# Trimmable Nanosecond Time-of-Day Counter

This block keeps a free-running nanosecond count that grows by a programmable step on every reference clock cycle. Software trims its rate through a correction scheme. A second, correction step replaces the normal step on one clock in every programmed number of running clocks. The count can wrap back toward zero at a programmable period, and a single-cycle pulse marks each such wrap when the pulse is enabled.

Software reaches the block through a small word-addressed write/read port. Reads of the count go through a snapshot register. A capture strobe in the control word copies the live count into the snapshot, so a read always returns one coherent value. Software can also load the count directly, or clear it together with the correction sequencer through a restart strobe.

Register words: 0 control, 1 count (read returns the snapshot, a write loads the live count), 2 wrap period, 3 trim interval, 4 step pair. Any other address reads as zero.

Top module: `ns_tod_counter`

## Requirements
- R1: After reset the count, the snapshot, the period, the trim interval, both steps and all control bits are zero, `wrapPulse` is low, and every address reads 0.
- R2: While control bit 0 (run) is 1, the count grows by the selected step on every clock. While it is 0, the count holds its value.
- R3: With a trim interval T other than 0, the correction step (step word bits 14:8) is used on one running clock in every T+1. After a restart or reset, the first such clock is the (T+1)th running clock. The normal step is used on all other running clocks.
- R4: With a trim interval of 0, only the normal step (step word bits 6:0) is ever used.
- R5: With control bit 1 (wrap enable) set, a sum of count plus step that is greater than or equal to the period becomes sum minus period. With the period at 2^31, the count therefore behaves as a 31-bit wrapping nanosecond count.
- R6: With wrap enable clear, the count wraps modulo 2^32 and no pulse is produced.
- R7: `wrapPulse` is high for one cycle, in the cycle the wrapped count first appears. It does so only when control bit 2 (pulse enable) is set.
- R8: Writing control bit 3 as 1 copies the count held before that clock edge into the snapshot. Reads of word 1 return the snapshot, which holds until the next capture.
- R9: A write to word 1 replaces the count at that edge and takes priority over the step added on that clock.
- R10: Writing control bit 4 as 1 clears the count and the correction sequencer. This overrides a load and the step on that clock.
- R11: Control bits 3 and 4 are strobes. A control read returns only bits 2:0, with every other bit 0.
- R12: The step word keeps the normal step in bits 6:0 and the correction step in bits 14:8, and reads back with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| wrapPulse | output | 1 | One-cycle pulse on a period wrap |

## Verification
The bench builds the block with its default widths: a 32-bit count and 7-bit steps, so the correction step sits at bits 14:8. At these widths a period of 2^31 can be loaded directly. Starting the count a few steps below that boundary reaches the 31-bit wrap within cycles. A start value just under 2^32 likewise reaches the natural overflow with wrap disabled. Small periods that do not divide evenly by the step make the remainder kept by the wrap visible.

// File: rtl/ns_tod_pkg.sv
package ns_tod_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_COUNT  = 3'd1,
    REG_PERIOD = 3'd2,
    REG_TRIM   = 3'd3,
    REG_STEP   = 3'd4
  } regSel_e;

  // control word bit positions
  localparam int CTL_RUN     = 0;
  localparam int CTL_WRAP    = 1;
  localparam int CTL_PULSE   = 2;
  localparam int CTL_CAPTURE = 3;
  localparam int CTL_RESTART = 4;

  // strobes and modes from control to datapath
  typedef struct packed {
    logic run;
    logic wrapEn;
    logic pulseEn;
    logic useCorr;
    logic load;
    logic capture;
    logic restart;
  } dpCmd_t;

endpackage

// File: rtl/ns_tod_ctrl.sv
module ns_tod_ctrl
  import ns_tod_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [CNT_W-1:0]     snapshot,
  output dpCmd_t               cmd,
  output logic [CNT_W-1:0]     period,
  output logic [INC_W-1:0]     stepNorm,
  output logic [INC_W-1:0]     stepCorr,
  output logic [CNT_W-1:0]     rdData
);

  localparam int CORR_LSB = INC_W + 1;

  logic             cfgRun, cfgWrap, cfgPulse;
  logic [CNT_W-1:0] trim;
  logic [CNT_W-1:0] corrCnt;
  logic             ctrlWr, countWr, periodWr, trimWr, stepWr;
  logic             corrDue, trimOn;

  assign ctrlWr   = wrEn && (addr == REG_CTRL);
  assign countWr  = wrEn && (addr == REG_COUNT);
  assign periodWr = wrEn && (addr == REG_PERIOD);
  assign trimWr   = wrEn && (addr == REG_TRIM);
  assign stepWr   = wrEn && (addr == REG_STEP);

  assign trimOn  = (trim != '0);
  assign corrDue = cfgRun && trimOn && (corrCnt >= trim);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRun   <= 1'b0;
      cfgWrap  <= 1'b0;
      cfgPulse <= 1'b0;
      period   <= '0;
      trim     <= '0;
      stepNorm <= '0;
      stepCorr <= '0;
    end else begin
      if (ctrlWr) begin
        cfgRun   <= wrData[CTL_RUN];
        cfgWrap  <= wrData[CTL_WRAP];
        cfgPulse <= wrData[CTL_PULSE];
      end
      if (periodWr) period <= wrData;
      if (trimWr)   trim   <= wrData;
      if (stepWr) begin
        stepNorm <= wrData[INC_W-1:0];
        stepCorr <= wrData[CORR_LSB +: INC_W];
      end
    end
  end

  // correction sequencer: counts running clocks between correction steps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrCnt <= '0;
    end else if (ctrlWr && wrData[CTL_RESTART]) begin
      corrCnt <= '0;
    end else if (cfgRun && trimOn) begin
      corrCnt <= corrDue ? '0 : corrCnt + 1'b1;
    end
  end

  always_comb begin
    cmd.run     = cfgRun;
    cmd.wrapEn  = cfgWrap;
    cmd.pulseEn = cfgPulse;
    cmd.useCorr = corrDue;
    cmd.load    = countWr;
    cmd.capture = ctrlWr && wrData[CTL_CAPTURE];
    cmd.restart = ctrlWr && wrData[CTL_RESTART];
  end

  // read mux
  always_comb begin
    rdData = '0;
    case (addr)
      REG_CTRL: begin
        rdData[CTL_RUN]   = cfgRun;
        rdData[CTL_WRAP]  = cfgWrap;
        rdData[CTL_PULSE] = cfgPulse;
      end
      REG_COUNT:  rdData = snapshot;
      REG_PERIOD: rdData = period;
      REG_TRIM:   rdData = trim;
      REG_STEP: begin
        rdData[INC_W-1:0]          = stepNorm;
        rdData[CORR_LSB +: INC_W]  = stepCorr;
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/ns_tod_dp.sv
module ns_tod_dp
  import ns_tod_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [CNT_W-1:0]  loadValue,
  input  logic [CNT_W-1:0]  period,
  input  logic [INC_W-1:0]  stepNorm,
  input  logic [INC_W-1:0]  stepCorr,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  snapshot,
  output logic              wrapPulse
);

  localparam int SUM_W = CNT_W + 1;

  logic [INC_W-1:0] stepSel;
  logic [SUM_W-1:0] sum, wrapped;
  logic             wrapHit;
  logic [CNT_W-1:0] nextCount;

  assign stepSel = cmd.useCorr ? stepCorr : stepNorm;
  assign sum     = {1'b0, count} + {{(SUM_W-INC_W){1'b0}}, stepSel};
  assign wrapHit = cmd.wrapEn && (sum >= {1'b0, period});
  assign wrapped = sum - {1'b0, period};

  always_comb begin
    if (wrapHit) nextCount = wrapped[CNT_W-1:0];
    else         nextCount = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      wrapPulse <= 1'b0;
    end else if (cmd.restart) begin
      count     <= '0;
      wrapPulse <= 1'b0;
    end else if (cmd.load) begin
      count     <= loadValue;
      wrapPulse <= 1'b0;
    end else if (cmd.run) begin
      count     <= nextCount;
      wrapPulse <= wrapHit && cmd.pulseEn;
    end else begin
      wrapPulse <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            snapshot <= '0;
    else if (cmd.capture) snapshot <= count;
  end

endmodule

// File: rtl/ns_tod_counter.sv
module ns_tod_counter
  import ns_tod_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              wrapPulse
);

  dpCmd_t           cmd;
  logic [CNT_W-1:0] period, count, snapshot;
  logic [INC_W-1:0] stepNorm, stepCorr;

  ns_tod_ctrl #(.CNT_W(CNT_W), .INC_W(INC_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .snapshot (snapshot),
    .cmd      (cmd),
    .period   (period),
    .stepNorm (stepNorm),
    .stepCorr (stepCorr),
    .rdData   (rdData)
  );

  ns_tod_dp #(.CNT_W(CNT_W), .INC_W(INC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .loadValue (wrData),
    .period    (period),
    .stepNorm  (stepNorm),
    .stepCorr  (stepCorr),
    .count     (count),
    .snapshot  (snapshot),
    .wrapPulse (wrapPulse)
  );

endmodule

// File: rtl/ns_tod_counter_chk.sv
module ns_tod_counter_chk
  import ns_tod_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input dpCmd_t           cmd,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] snapshot,
  input logic             wrapPulse
);

  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (count == '0));

  a_r9_load_value: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && !cmd.restart) |=> (count == $past(wrData)));

  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.load && !cmd.restart) |=> $stable(count));

  a_r8_capture_copies: assert property (@(posedge clk) disable iff (!rstN)
    cmd.capture |=> (snapshot == $past(count)));

  a_r8_snapshot_holds: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.capture |=> $stable(snapshot));

  a_r7_pulse_gated: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> ($past(cmd.pulseEn) && $past(cmd.wrapEn) && $past(cmd.run)));

  a_r3_corr_only_running: assert property (@(posedge clk) disable iff (!rstN)
    cmd.useCorr |-> cmd.run);

endmodule

bind ns_tod_counter ns_tod_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmd       (cmd),
  .wrData    (wrData),
  .count     (count),
  .snapshot  (snapshot),
  .wrapPulse (wrapPulse)
);

// File: tb/ns_tod_counter_tb.sv
module ns_tod_counter_tb;

  localparam int CNT_W = 32;
  localparam int INC_W = 7;
  localparam int WATCHDOG = 20000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [2:0]       addr = 3'd0;
  logic [CNT_W-1:0] wrData = '0;
  logic [CNT_W-1:0] rdData;
  logic             wrapPulse;

  int compared = 0;
  int mismatched = 0;
  int pulseSeen = 0;
  int cyc = 0;

  typedef struct {
    string       tag;
    logic [31:0] exp;
  } item_t;
  item_t expQ[$];
  event  sampleEv;

  // reference model state
  logic [CNT_W-1:0] mCount = '0, mSnap = '0, mPeriod = '0, mTrim = '0, mCorrCnt = '0;
  logic [INC_W-1:0] mStepN = '0, mStepC = '0;
  logic             mRun = 1'b0, mWrap = 1'b0, mPulseEn = 1'b0, mPulse = 1'b0;

  always #10 clk = ~clk;

  ns_tod_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .wrapPulse(wrapPulse)
  );

  task automatic report(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model built from the requirements, stepped on the same edges
  always @(posedge clk) begin : mdl
    logic [CNT_W:0]   s;
    logic [INC_W-1:0] st;
    logic             uc, hit, capt, rs, ld;
    if (!rstN) begin
      mCount = '0; mSnap = '0; mPeriod = '0; mTrim = '0; mCorrCnt = '0;
      mStepN = '0; mStepC = '0; mRun = 1'b0; mWrap = 1'b0; mPulseEn = 1'b0; mPulse = 1'b0;
    end else begin
      capt = wrEn && addr == 3'd0 && wrData[3];
      rs   = wrEn && addr == 3'd0 && wrData[4];
      ld   = wrEn && addr == 3'd1;
      uc   = mRun && (mTrim != '0) && (mCorrCnt >= mTrim);
      st   = uc ? mStepC : mStepN;
      s    = {1'b0, mCount} + {{(CNT_W+1-INC_W){1'b0}}, st};
      hit  = mWrap && (s >= {1'b0, mPeriod});
      if (capt) mSnap = mCount;
      if (rs) begin
        mCount = '0; mPulse = 1'b0; mCorrCnt = '0;
      end else begin
        if (mRun && mTrim != '0) mCorrCnt = uc ? '0 : mCorrCnt + 1'b1;
        if (ld) begin
          mCount = wrData; mPulse = 1'b0;
        end else if (mRun) begin
          mCount = hit ? CNT_W'(s - {1'b0, mPeriod}) : s[CNT_W-1:0];
          mPulse = hit && mPulseEn;
        end else begin
          mPulse = 1'b0;
        end
      end
      if (wrEn && addr == 3'd0) begin
        mRun = wrData[0]; mWrap = wrData[1]; mPulseEn = wrData[2];
      end
      if (wrEn && addr == 3'd2) mPeriod = wrData;
      if (wrEn && addr == 3'd3) mTrim = wrData;
      if (wrEn && addr == 3'd4) begin
        mStepN = wrData[6:0]; mStepC = wrData[14:8];
      end
    end
  end

  // pulse monitor (R7)
  always @(negedge clk) begin
    if (rstN) begin
      if (wrapPulse) pulseSeen++;
      if (wrapPulse || mPulse) report({31'd0, wrapPulse}, {31'd0, mPulse}, "R7 pulse vs model");
    end
  end

  // scoreboard monitor for register reads
  initial begin
    forever begin
      item_t it;
      @(sampleEv);
      #1;
      it = expQ.pop_front();
      report(rdData, it.exp, it.tag);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdCheck(input logic [2:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    wrEn = 1'b0; addr = a;
    it.tag = tag; it.exp = exp;
    expQ.push_back(it);
    -> sampleEv;
    @(negedge clk);
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 6; i++) rdCheck(3'(i), 32'd0, "R1 reset read");
    report({31'd0, wrapPulse}, 32'd0, "R1 pulse low");

    // R12 step layout, R11 control readback, R9 load over running step, R8 capture
    wr(3'd4, 32'h0000_0908);
    rdCheck(3'd4, 32'h0000_0908, "R12 step readback");
    wr(3'd0, 32'd1);
    rdCheck(3'd0, 32'd1, "R11 ctrl readback");
    wr(3'd1, 32'd100);
    wr(3'd0, 32'd1 | 32'd8);
    rdCheck(3'd0, 32'd1, "R11 strobe reads zero");
    rdCheck(3'd1, 32'd100, "R9 load value");
    repeat (5) @(negedge clk);
    rdCheck(3'd1, 32'd100, "R8 snapshot holds");

    // R2 halt: count stays while run is clear
    wr(3'd0, 32'd0);
    wr(3'd0, 32'd8);
    p0 = 0;
    rdCheck(3'd1, mSnap, "R2 halted capture");
    repeat (4) @(negedge clk);
    wr(3'd0, 32'd8);
    rdCheck(3'd1, mSnap, "R2 halted stable");

    // R3 correction every T+1 running clocks, T=3: 9 normal + 2 corr = 90
    wr(3'd3, 32'd3);
    wr(3'd0, 32'd16);
    wr(3'd0, 32'd1);
    repeat (11) @(negedge clk);
    wr(3'd0, 32'd1 | 32'd8);
    rdCheck(3'd1, 32'd90, "R3 correction step");

    // R4 trim zero: 9 clocks of 8 = 72
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd1 | 32'd16);
    repeat (9) @(negedge clk);
    wr(3'd0, 32'd1 | 32'd8);
    rdCheck(3'd1, 32'd72, "R4 normal only");

    // R5/R7 31-bit wrap at period 2^31
    wr(3'd0, 32'd0);
    wr(3'd2, 32'h8000_0000);
    wr(3'd1, 32'h7FFF_FFF0);
    p0 = pulseSeen;
    wr(3'd0, 32'd7);
    @(negedge clk);
    wr(3'd0, 32'd7 | 32'd8);
    report({31'd0, wrapPulse}, 32'd1, "R7 pulse on wrap");
    rdCheck(3'd1, 32'h7FFF_FFF8, "R5 before wrap");
    wr(3'd0, 32'd7 | 32'd8);
    rdCheck(3'd1, 32'd8, "R5 after 31-bit wrap");
    report(32'(pulseSeen - p0), 32'd1, "R7 single pulse");

    // R5 remainder kept: period 100, 96+8 -> 4
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd100);
    wr(3'd1, 32'd96);
    wr(3'd0, 32'd7);
    wr(3'd0, 32'd7 | 32'd8);
    wr(3'd0, 32'd8);
    rdCheck(3'd1, 32'd4, "R5 remainder");

    // R6 no wrap enable: modulo 2^32, no pulse
    wr(3'd0, 32'd0);
    wr(3'd1, 32'hFFFF_FFF8);
    p0 = pulseSeen;
    wr(3'd0, 32'd5);
    wr(3'd0, 32'd5 | 32'd8);
    wr(3'd0, 32'd5 | 32'd8);
    rdCheck(3'd1, 32'd0, "R6 natural overflow");
    report(32'(pulseSeen - p0), 32'd0, "R6 no pulse");

    // R7 pulse enable clear: wrap without pulse
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd88);
    p0 = pulseSeen;
    wr(3'd0, 32'd3);
    repeat (3) @(negedge clk);
    wr(3'd0, 32'd3 | 32'd8);
    rdCheck(3'd1, 32'd12, "R7 wrap with pulse disabled");
    report(32'(pulseSeen - p0), 32'd0, "R7 no pulse when disabled");

    // R10 restart with capture
    wr(3'd0, 32'd1 | 32'd8 | 32'd16);
    wr(3'd0, 32'd8);
    rdCheck(3'd1, 32'd0, "R10 restart clears");
    rdCheck(3'd0, 32'd0, "R11 ctrl after strobes");

    // R12 field widths
    wr(3'd4, 32'hFFFF_FFFF);
    rdCheck(3'd4, 32'h0000_7F7F, "R12 unused step bits");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule